// File: doc/BRIEF.md
# Sector DMA Engine with Field Wrap

This engine copies one disk sector between a 12-bit-word main memory and a disk word store. A scheduler pulses `start_i` once the seek and rotation delay of a read or write has run out. The engine then takes the controller's command word, disk address and memory address. It checks that the selected drive can accept the job and moves the words one per clock over two valid/ready ports. On completion it reports the new memory-address value together with a done indication. When the engine has finished, it is idle again.

The memory address is a 3-bit field number above a 12-bit offset. The offset wraps inside its 4K field, and a carry never reaches the field bits. A sector is 256 words, or 128 words when the half-sector bit is set. A half-sector write is followed by 128 zero words, so the disk always receives a whole sector. A read that reaches past the end of stored disk data delivers zeros to memory.

Top module: `sector_dma_engine`

## Requirements
- R1: A start while `drv_present_i` is low moves no word. In the next cycle it pulses `done_o`, `err_nrdy_o` and `err_dstat_o` together, and it does not pulse `ma_upd_o`.
- R2: A start for a write while `drv_wprot_i` is high moves no word. In the next cycle it pulses `done_o` and `err_wlk_o`, and it does not pulse `ma_upd_o`. A read to a protected drive runs normally.
- R3: The memory address of data word k is `{cmd_i[5:3], (madr_i + k) mod 4096}`. Passing offset 4095 continues at offset 0 of the same field.
- R4: The disk address of beat k is `{cmd_i[0], dadr_i, k[7:0]}`, which equals the sector number times 256, plus k.
- R5: The data length is 256 words when `cmd_i[6]` is 0 and 128 words when it is 1.
- R6: A function field `cmd_i[11:9]` of 4 or 5 is a write: memory words are read (`mem_we_o`=0) and written to disk (`dsk_we_o`=1). A field of 0 or 1 is a read: disk words are written to memory.
- R7: A half-sector write adds 128 disk-only beats after its data. These beats write zero to disk addresses k = 128..255 with `mem_valid_o` low.
- R8: During a read, a disk word for which `dsk_eod_i` is high is written to memory as zero.
- R9: A word moves only in a cycle where both `mem_ready_i` and `dsk_ready_i` are high. Pad beats need only `dsk_ready_i`. A memory handshake never happens without the matching disk handshake. After reset no valid is raised.
- R10: The cycle after the last beat, the engine pulses `done_o` and `ma_upd_o`, with `ma_new_o` = (`madr_i` + length) mod 4096, and `busy_o` is low.
- R11: A `start_i` pulse while `busy_o` is high is ignored. The running job keeps its addresses, direction and length, even if the input values change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the sector job (one-cycle pulse) |
| cmd_i | input | 12 | Command word: [11:9] function, [6] half sector, [5:3] field, [0] cylinder high bit |
| dadr_i | input | 12 | Disk address register |
| madr_i | input | 12 | Memory address register (offset within field) |
| drv_present_i | input | 1 | Selected drive is present |
| drv_wprot_i | input | 1 | Selected drive is write protected |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory can take a request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 15 | Physical memory word address |
| mem_wdata_o | output | 12 | Word written to memory |
| mem_rdata_i | input | 12 | Word read from memory at `mem_addr_o` |
| dsk_valid_o | output | 1 | Disk request valid |
| dsk_ready_i | input | 1 | Disk store can take a request |
| dsk_we_o | output | 1 | Disk write (1) or read (0) |
| dsk_addr_o | output | 21 | Disk word address |
| dsk_wdata_o | output | 12 | Word written to disk |
| dsk_rdata_i | input | 12 | Word read from disk at `dsk_addr_o` |
| dsk_eod_i | input | 1 | Addressed disk word lies past the stored data |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | Job finished or aborted (pulse) |
| err_nrdy_o | output | 1 | Drive not ready (pulse with done) |
| err_dstat_o | output | 1 | Drive status error (pulse with done) |
| err_wlk_o | output | 1 | Write-lock error (pulse with done) |
| ma_upd_o | output | 1 | Load `ma_new_o` into the memory address register |
| ma_new_o | output | 12 | Advanced memory address |

## Verification
The hardest state to reach is a half-sector write that starts near the top of a field while both ready signals stall at random. Its data beats then cross the 4095-to-0 wrap and run straight into the disk-only pad beats. A directed case starting at offset 4095 covers this, and random jobs with random readiness add more. The bench also reaches a start pulse that lands mid-job with changed input values, by raising `start_i` a few cycles after a job begins. It confirms that the logged addresses and the reported memory address still match the original job.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  localparam int CMD_W        = 12;
  localparam int CMD_WR_BIT   = 11;
  localparam int CMD_HALF_BIT = 6;
  localparam int CMD_EXT_LSB  = 3;
  localparam int CMD_CYHI_BIT = 0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_PAD  = 2'd2
  } sdma_state_e;

endpackage

// File: rtl/sdma_rst_sync.sv
module sdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/sdma_decode.sv
module sdma_decode
  import sdma_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int EXT_W  = 3
) (
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [WORD_W-1:0] dadr_i,
  output logic              wr_o,
  output logic              half_o,
  output logic [EXT_W-1:0]  field_o,
  output logic [WORD_W:0]   sector_o
);

  // Function codes 4/5 are writes, 0/1 reads: only the top bit matters here.
  assign wr_o     = cmd_i[CMD_WR_BIT];
  assign half_o   = cmd_i[CMD_HALF_BIT];
  assign field_o  = cmd_i[CMD_EXT_LSB +: EXT_W];
  assign sector_o = {cmd_i[CMD_CYHI_BIT], dadr_i};

  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{cmd_i[CMD_WR_BIT-1:CMD_HALF_BIT+1],
                             cmd_i[CMD_EXT_LSB-1:CMD_CYHI_BIT+1]};

endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int EXT_W     = 3,
  parameter int SECT_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dec_wr_i,
  input  logic              dec_half_i,
  input  logic [EXT_W-1:0]  dec_field_i,
  input  logic [WORD_W:0]   dec_sector_i,
  input  logic [WORD_W-1:0] madr_i,
  input  logic              drv_present_i,
  input  logic              drv_wprot_i,
  input  logic              mem_ready_i,
  input  logic              dsk_ready_i,
  output sdma_state_e       state_o,
  output logic              wr_o,
  output logic [EXT_W-1:0]  field_o,
  output logic [WORD_W-1:0] off_o,
  output logic [WORD_W:0]   sector_o,
  output logic [SECT_LOG2-1:0] idx_o,
  output logic              done_o,
  output logic              err_nrdy_o,
  output logic              err_dstat_o,
  output logic              err_wlk_o,
  output logic              ma_upd_o,
  output logic [WORD_W-1:0] ma_new_o
);

  localparam int IDX_W  = SECT_LOG2;
  localparam int FULL_N = 1 << SECT_LOG2;
  localparam int HALF_N = FULL_N / 2;

  sdma_state_e       state_q, state_d;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] off_q, ma_new_q;
  logic [EXT_W-1:0]  field_q;
  logic [WORD_W:0]   sector_q;
  logic              wr_q, half_q;
  logic              done_q, nrdy_q, dstat_q, wlk_q, maupd_q;
  logic              done_d, nrdy_d, dstat_d, wlk_d, maupd_d;
  logic              job_en, step_en, beat, last_data, last_pad;
  logic [WORD_W-1:0] len_in;

  assign len_in    = dec_half_i ? WORD_W'(HALF_N) : WORD_W'(FULL_N);
  assign last_data = (idx_q == (half_q ? IDX_W'(HALF_N - 1) : IDX_W'(FULL_N - 1)));
  assign last_pad  = (idx_q == IDX_W'(FULL_N - 1));

  always_comb begin
    unique case (state_q)
      ST_DATA: beat = mem_ready_i & dsk_ready_i;
      ST_PAD:  beat = dsk_ready_i;
      default: beat = 1'b0;
    endcase
  end

  // Next-state process
  always_comb begin
    state_d = state_q;
    job_en  = 1'b0;
    step_en = 1'b0;
    done_d  = 1'b0;
    nrdy_d  = 1'b0;
    dstat_d = 1'b0;
    wlk_d   = 1'b0;
    maupd_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (!drv_present_i) begin
            done_d  = 1'b1;
            nrdy_d  = 1'b1;
            dstat_d = 1'b1;
          end else if (dec_wr_i && drv_wprot_i) begin
            done_d = 1'b1;
            wlk_d  = 1'b1;
          end else begin
            job_en  = 1'b1;
            state_d = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (beat) begin
          step_en = 1'b1;
          if (last_data) begin
            if (wr_q && half_q) begin
              state_d = ST_PAD;
            end else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
              maupd_d = 1'b1;
            end
          end
        end
      end
      ST_PAD: begin
        if (beat) begin
          step_en = 1'b1;
          if (last_pad) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            maupd_d = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      nrdy_q  <= 1'b0;
      dstat_q <= 1'b0;
      wlk_q   <= 1'b0;
      maupd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      nrdy_q  <= nrdy_d;
      dstat_q <= dstat_d;
      wlk_q   <= wlk_d;
      maupd_q <= maupd_d;
    end
  end

  // Job registers, loaded on acceptance only
  always_ff @(posedge clk) begin
    if (job_en) begin
      wr_q     <= dec_wr_i;
      half_q   <= dec_half_i;
      field_q  <= dec_field_i;
      sector_q <= dec_sector_i;
      ma_new_q <= madr_i + len_in;
    end
  end

  // Beat counters: offset wraps inside the field by its own width
  always_ff @(posedge clk) begin
    if (job_en) begin
      idx_q <= '0;
      off_q <= madr_i;
    end else if (step_en) begin
      idx_q <= idx_q + IDX_W'(1);
      off_q <= off_q + WORD_W'(1);
    end
  end

  assign state_o     = state_q;
  assign wr_o        = wr_q;
  assign field_o     = field_q;
  assign off_o       = off_q;
  assign sector_o    = sector_q;
  assign idx_o       = idx_q;
  assign done_o      = done_q;
  assign err_nrdy_o  = nrdy_q;
  assign err_dstat_o = dstat_q;
  assign err_wlk_o   = wlk_q;
  assign ma_upd_o    = maupd_q;
  assign ma_new_o    = ma_new_q;

  p_pad_half_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAD) |-> (wr_q && half_q));

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start_i) |=> ($stable(sector_q) && $stable(field_q) && $stable(wr_q) && $stable(ma_new_q)));

  p_one_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nrdy_q, wlk_q, maupd_q}));

endmodule

// File: rtl/sdma_port_mux.sv
module sdma_port_mux
  import sdma_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int EXT_W     = 3,
  parameter int SECT_LOG2 = 8,
  localparam int PA_W     = EXT_W + WORD_W,
  localparam int DA_W     = 1 + WORD_W + SECT_LOG2
) (
  input  sdma_state_e          state_i,
  input  logic                 wr_i,
  input  logic [EXT_W-1:0]     field_i,
  input  logic [WORD_W-1:0]    off_i,
  input  logic [WORD_W:0]      sector_i,
  input  logic [SECT_LOG2-1:0] idx_i,
  input  logic                 mem_ready_i,
  input  logic                 dsk_ready_i,
  input  logic [WORD_W-1:0]    mem_rdata_i,
  input  logic [WORD_W-1:0]    dsk_rdata_i,
  input  logic                 dsk_eod_i,
  output logic                 mem_valid_o,
  output logic                 mem_we_o,
  output logic [PA_W-1:0]      mem_addr_o,
  output logic [WORD_W-1:0]    mem_wdata_o,
  output logic                 dsk_valid_o,
  output logic                 dsk_we_o,
  output logic [DA_W-1:0]      dsk_addr_o,
  output logic [WORD_W-1:0]    dsk_wdata_o
);

  logic in_data, in_pad;

  assign in_data = (state_i == ST_DATA);
  assign in_pad  = (state_i == ST_PAD);

  // Each valid carries the other side's ready, so a handshake on one side
  // always coincides with a handshake on the other.
  assign mem_valid_o = in_data & dsk_ready_i;
  assign dsk_valid_o = (in_data & mem_ready_i) | in_pad;

  assign mem_we_o = in_data & ~wr_i;
  assign dsk_we_o = (in_data & wr_i) | in_pad;

  assign mem_addr_o = {field_i, off_i};
  assign dsk_addr_o = {sector_i, idx_i};

  assign mem_wdata_o = (in_data && !wr_i && !dsk_eod_i) ? dsk_rdata_i : '0;
  assign dsk_wdata_o = (in_data && wr_i) ? mem_rdata_i : '0;

endmodule

// File: rtl/sector_dma_engine.sv
module sector_dma_engine
  import sdma_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int EXT_W     = 3,
  parameter int SECT_LOG2 = 8,
  localparam int PA_W     = EXT_W + WORD_W,
  localparam int DA_W     = 1 + WORD_W + SECT_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [WORD_W-1:0] dadr_i,
  input  logic [WORD_W-1:0] madr_i,
  input  logic              drv_present_i,
  input  logic              drv_wprot_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              dsk_valid_o,
  input  logic              dsk_ready_i,
  output logic              dsk_we_o,
  output logic [DA_W-1:0]   dsk_addr_o,
  output logic [WORD_W-1:0] dsk_wdata_o,
  input  logic [WORD_W-1:0] dsk_rdata_i,
  input  logic              dsk_eod_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_nrdy_o,
  output logic              err_dstat_o,
  output logic              err_wlk_o,
  output logic              ma_upd_o,
  output logic [WORD_W-1:0] ma_new_o
);

  logic                 rst_ns;
  logic                 dec_wr, dec_half;
  logic [EXT_W-1:0]     dec_field, job_field;
  logic [WORD_W:0]      dec_sector, job_sector;
  sdma_state_e          state;
  logic                 job_wr;
  logic [WORD_W-1:0]    job_off;
  logic [SECT_LOG2-1:0] job_idx;

  sdma_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_ns)
  );

  sdma_decode #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_dec (
    .cmd_i    (cmd_i),
    .dadr_i   (dadr_i),
    .wr_o     (dec_wr),
    .half_o   (dec_half),
    .field_o  (dec_field),
    .sector_o (dec_sector)
  );

  sdma_ctrl #(.WORD_W(WORD_W), .EXT_W(EXT_W), .SECT_LOG2(SECT_LOG2)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_ns),
    .start_i       (start_i),
    .dec_wr_i      (dec_wr),
    .dec_half_i    (dec_half),
    .dec_field_i   (dec_field),
    .dec_sector_i  (dec_sector),
    .madr_i        (madr_i),
    .drv_present_i (drv_present_i),
    .drv_wprot_i   (drv_wprot_i),
    .mem_ready_i   (mem_ready_i),
    .dsk_ready_i   (dsk_ready_i),
    .state_o       (state),
    .wr_o          (job_wr),
    .field_o       (job_field),
    .off_o         (job_off),
    .sector_o      (job_sector),
    .idx_o         (job_idx),
    .done_o        (done_o),
    .err_nrdy_o    (err_nrdy_o),
    .err_dstat_o   (err_dstat_o),
    .err_wlk_o     (err_wlk_o),
    .ma_upd_o      (ma_upd_o),
    .ma_new_o      (ma_new_o)
  );

  sdma_port_mux #(.WORD_W(WORD_W), .EXT_W(EXT_W), .SECT_LOG2(SECT_LOG2)) u_mux (
    .state_i     (state),
    .wr_i        (job_wr),
    .field_i     (job_field),
    .off_i       (job_off),
    .sector_i    (job_sector),
    .idx_i       (job_idx),
    .mem_ready_i (mem_ready_i),
    .dsk_ready_i (dsk_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .dsk_rdata_i (dsk_rdata_i),
    .dsk_eod_i   (dsk_eod_i),
    .mem_valid_o (mem_valid_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .dsk_valid_o (dsk_valid_o),
    .dsk_we_o    (dsk_we_o),
    .dsk_addr_o  (dsk_addr_o),
    .dsk_wdata_o (dsk_wdata_o)
  );

  assign busy_o = (state != ST_IDLE);

  p_abort_flags_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    err_nrdy_o |-> (done_o && err_dstat_o && !ma_upd_o));

  p_wlk_no_update_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    err_wlk_o |-> (done_o && !ma_upd_o && !err_nrdy_o));

  p_field_hold_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy_o && $past(busy_o)) |-> (mem_addr_o[PA_W-1 -: EXT_W] == $past(mem_addr_o[PA_W-1 -: EXT_W])));

  p_beat_pair_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_valid_o && mem_ready_i) |-> (dsk_valid_o && dsk_ready_i));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    done_o |-> !busy_o);

endmodule

// File: tb/sector_dma_engine_tb_top.sv
module sector_dma_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [11:0] cmd_i, dadr_i, madr_i;
  logic        drv_present_i, drv_wprot_i;
  logic        mem_valid_o, mem_ready_i, mem_we_o;
  logic [14:0] mem_addr_o;
  logic [11:0] mem_wdata_o, mem_rdata_i;
  logic        dsk_valid_o, dsk_ready_i, dsk_we_o;
  logic [20:0] dsk_addr_o;
  logic [11:0] dsk_wdata_o, dsk_rdata_i;
  logic        dsk_eod_i;
  logic        busy_o, done_o, err_nrdy_o, err_dstat_o, err_wlk_o, ma_upd_o;
  logic [11:0] ma_new_o;

  always #5 clk = ~clk;

  sector_dma_engine dut_i (.*);

  int unsigned eod_lim = 32'hFFFF_FFFF;
  bit          rand_rdy = 1'b0;
  int          n_checks = 0, n_fail = 0, cyc = 0;
  int          nb = 0, hs_err = 0, last_beat_cyc = 0;

  logic [14:0] l_ma [256];
  logic        l_mv [256];
  logic        l_mwe [256];
  logic [11:0] l_mwd [256];
  logic [20:0] l_da [256];
  logic        l_dwe [256];
  logic [11:0] l_dwd [256];

  function automatic logic [11:0] pat_m(logic [14:0] a);
    return a[11:0] ^ {a[14:12], 9'h0A5} ^ 12'h3C1;
  endfunction

  function automatic logic [11:0] pat_d(logic [20:0] a);
    return a[11:0] ^ {a[20:13], 4'h9};
  endfunction

  assign mem_rdata_i = pat_m(mem_addr_o);
  assign dsk_rdata_i = pat_d(dsk_addr_o);
  assign dsk_eod_i   = (32'(dsk_addr_o) >= eod_lim);

  always @(negedge clk) begin
    if (rand_rdy) begin
      mem_ready_i = (($urandom % 4) != 0);
      dsk_ready_i = (($urandom % 4) != 0);
    end else begin
      mem_ready_i = 1'b1;
      dsk_ready_i = 1'b1;
    end
  end

  // Beat monitor: samples pre-edge values at each rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_valid_o && mem_ready_i && !(dsk_valid_o && dsk_ready_i)) hs_err++;
      if (dsk_valid_o && dsk_ready_i) begin
        if (nb < 256) begin
          l_ma[nb]  = mem_addr_o;
          l_mv[nb]  = mem_valid_o && mem_ready_i;
          l_mwe[nb] = mem_we_o;
          l_mwd[nb] = mem_wdata_o;
          l_da[nb]  = dsk_addr_o;
          l_dwe[nb] = dsk_we_o;
          l_dwd[nb] = dsk_wdata_o;
        end
        nb++;
        last_beat_cyc = cyc;
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] mk_cmd(int fn, bit half, int field, bit cyhi);
    return 12'((fn & 7) << 9) | (half ? 12'o0100 : 12'o0) | 12'((field & 7) << 3) | {11'd0, cyhi};
  endfunction

  task automatic run(logic [11:0] cmd, logic [11:0] da, logic [11:0] ma,
                     bit present, bit prot, int unsigned eod, bit rr, bit disturb);
    bit got = 0;
    bit f_nrdy = 0, f_dstat = 0, f_wlk = 0, f_upd = 0, f_busy = 0, f_time = 0;
    logic [11:0] f_ma = '0;
    bit wr, half, ab_n, ab_w;
    int len, exp_nb, e3 = 0, e4 = 0, e6 = 0, e7 = 0, e8 = 0;
    logic [12:0] sector;
    @(negedge clk);
    rand_rdy = rr; eod_lim = eod;
    nb = 0; hs_err = 0;
    cmd_i = cmd; dadr_i = da; madr_i = ma;
    drv_present_i = present; drv_wprot_i = prot;
    start_i = 1'b1;
    for (int k = 0; k < 3000 && !got; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (disturb && k == 5) begin
        start_i = 1'b1;
        cmd_i = ~cmd; dadr_i = ~da; madr_i = ~ma;
      end
      if (done_o) begin
        got = 1;
        f_nrdy = err_nrdy_o; f_dstat = err_dstat_o; f_wlk = err_wlk_o;
        f_upd = ma_upd_o; f_ma = ma_new_o; f_busy = busy_o;
        f_time = (cyc == last_beat_cyc);
      end
    end
    start_i = 1'b0;
    wr = cmd[11]; half = cmd[6]; len = half ? 128 : 256;
    sector = {cmd[0], da};
    ab_n = !present; ab_w = present && wr && prot;
    check(got, "R10", "done seen", int'(got), 1);
    if (ab_n) begin
      check(f_nrdy && f_dstat && !f_wlk && !f_upd, "R1", "abort flags nrdy/dstat/wlk/upd",
            {f_nrdy, f_dstat, f_wlk, f_upd}, 4'b1100);
      check(nb == 0, "R1", "beats on absent drive", nb, 0);
    end else if (ab_w) begin
      check(f_wlk && !f_nrdy && !f_dstat && !f_upd, "R2", "abort flags nrdy/dstat/wlk/upd",
            {f_nrdy, f_dstat, f_wlk, f_upd}, 4'b0010);
      check(nb == 0, "R2", "beats on protected write", nb, 0);
    end else begin
      exp_nb = (wr && half) ? 256 : len;
      check(nb == exp_nb, "R5", "beat count", nb, exp_nb);
      for (int k = 0; k < 256 && k < nb; k++) begin
        logic [20:0] eda;
        logic [14:0] epa;
        eda = {sector, 8'(k)};
        epa = {cmd[5:3], 12'(32'(ma) + k)};
        if (l_da[k] != eda) e4++;
        if (k < len) begin
          if (!l_mv[k] || l_ma[k] != epa) e3++;
          if (l_mwe[k] != !wr || l_dwe[k] != wr) e6++;
          if (wr) begin
            if (l_dwd[k] != pat_m(epa)) e6++;
          end else begin
            if (l_mwd[k] != ((32'(eda) >= eod) ? 12'd0 : pat_d(eda))) e8++;
          end
        end else begin
          if (l_mv[k] || !l_dwe[k] || l_dwd[k] != 12'd0) e7++;
        end
      end
      check(e3 == 0, "R3", "memory address mismatches", e3, 0);
      check(e4 == 0, "R4", "disk address mismatches", e4, 0);
      check(e6 == 0, "R6", "direction/write data mismatches", e6, 0);
      check(e8 == 0, "R8", "read data (zero past end) mismatches", e8, 0);
      if (wr && half) check(e7 == 0, "R7", "pad beat mismatches", e7, 0);
      check(f_upd && f_ma == 12'(32'(ma) + len), "R10", "new memory address",
            int'(f_ma), int'(12'(32'(ma) + len)));
      check(f_time && !f_busy, "R10", "done one cycle after last beat, idle", {f_time, f_busy}, 2'b10);
      check(!f_nrdy && !f_dstat && !f_wlk, "R2", "no error flags on accepted job",
            {f_nrdy, f_dstat, f_wlk}, 0);
      if (disturb) check(e3 == 0 && e4 == 0 && nb == exp_nb, "R11",
                         "start while busy ignored (addr errors)", e3 + e4, 0);
    end
    check(hs_err == 0, "R9", "memory handshake without disk handshake", hs_err, 0);
  endtask

  initial begin
    wait (cyc >= 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; cmd_i = '0; dadr_i = '0; madr_i = '0;
    drv_present_i = 1'b1; drv_wprot_i = 1'b0;
    mem_ready_i = 1'b1; dsk_ready_i = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy_o && !done_o && !mem_valid_o && !dsk_valid_o && !ma_upd_o, "R9",
          "reset idle state", {busy_o, done_o, mem_valid_o, dsk_valid_o, ma_upd_o}, 0);

    run(mk_cmd(0, 0, 2, 0), 12'h123, 12'd0,    1, 0, 32'hFFFF_FFFF, 0, 0); // R6 read full
    run(mk_cmd(0, 0, 7, 0), 12'h045, 12'd4000, 1, 0, 32'hFFFF_FFFF, 0, 0); // R3 wrap
    run(mk_cmd(4, 0, 3, 1), 12'hABC, 12'd100,  1, 0, 32'hFFFF_FFFF, 0, 0); // R4 cyl high, write
    run(mk_cmd(4, 1, 1, 0), 12'h200, 12'd4095, 1, 0, 32'hFFFF_FFFF, 1, 0); // R7 pad + wrap
    run(mk_cmd(1, 1, 5, 1), 12'h00F, 12'd2048, 1, 0, 32'hFFFF_FFFF, 0, 0); // R5 half read
    run(mk_cmd(0, 0, 0, 0), 12'h010, 12'd7,    1, 0, 32'd4096 + 77, 0, 0); // R8 end of data
    run(mk_cmd(0, 0, 4, 0), 12'h111, 12'd50,   0, 0, 32'hFFFF_FFFF, 0, 0); // R1 absent read
    run(mk_cmd(4, 1, 4, 0), 12'h111, 12'd50,   0, 1, 32'hFFFF_FFFF, 0, 0); // R1 absent write
    run(mk_cmd(5, 0, 6, 1), 12'h321, 12'd9,    1, 1, 32'hFFFF_FFFF, 0, 0); // R2 protected write
    run(mk_cmd(0, 0, 6, 1), 12'h321, 12'd9,    1, 1, 32'hFFFF_FFFF, 0, 0); // R2 protected read ok
    run(mk_cmd(4, 1, 2, 0), 12'h777, 12'd4000, 1, 0, 32'hFFFF_FFFF, 1, 1); // R11 restart ignored

    for (int i = 0; i < 30; i++) begin
      int fn;
      logic [11:0] c, d;
      int unsigned e;
      fn = (($urandom % 2) != 0 ? 4 : 0) + int'($urandom % 2);
      c = mk_cmd(fn, ($urandom % 2) != 0, int'($urandom % 8), ($urandom % 2) != 0);
      d = 12'($urandom);
      e = (($urandom % 2) != 0) ? ((32'({c[0], d}) << 8) + ($urandom % 320)) : 32'hFFFF_FFFF;
      run(c, d, 12'($urandom), ($urandom % 10) != 0, ($urandom % 3) == 0, e,
          ($urandom % 2) != 0, ($urandom % 5) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule